// File: doc/BRIEF.md
# Reset and Wake Start-up Sequencer

This block owns the chip's internal reset line. When the reset request rises, the internal reset rises in the same cycle. After the request falls, the block runs three timed phases in a fixed order before it lets the rest of the chip run. The first phase waits for the supply to settle and counts ticks of the slow oscillator. The second phase lets the main oscillator settle and counts its ticks. The third phase is a window of system cycles. In that window a strobe and a word index fetch calibration and configuration words from non-volatile storage.

Once running, the core can ask to sleep. A wake request then brings it back along a path chosen by the 2-bit sleep mode. Power-down counts main-oscillator ticks before running again. The lighter sleep modes resume on the next cycle. After reset the prescale output presents the code for the internal 8 MHz source divided by 8. The core is expected to load that code into its clock divider.

Top module: `startup_seq`

## Requirements
- R1: `int_rst` is high in the same cycle that `rst_req` is high, with no clock edge needed, and stays high while `rst_req` stays high.
- R2: After `rst_req` falls, the phases run in this order: supply delay, then oscillator count, then configuration window. `int_rst` falls on the first cycle after the last configuration word.
- R3: The supply delay ends on the SUPPLY_TICKS-th clock edge, counted after release, at which `slow_tick` is high (default 8192). `osc_tick` has no effect in this phase. No input can shorten the delay.
- R4: The oscillator phase ends on the OSC_CYCLES-th edge at which `osc_tick` is high (default 6). `slow_tick` has no effect in this phase.
- R5: The configuration window lasts CFG_WORDS cycles (default 21). In each of these cycles `cfg_load` is high, and `cfg_idx` counts from 0 up to CFG_WORDS-1. Outside the window `cfg_load` is 0 and `cfg_idx` is 0.
- R6: A new `rst_req` in any phase clears all progress. After the new release, the full sequence runs again from the supply delay.
- R7: While running, a `sleep_req` sampled at a clock edge drops `run_en` after that edge.
- R8: A `wake_req` while asleep with `sleep_mode` = 2'b10 (power-down) raises `run_en` only after WAKE_CYCLES edges at which `osc_tick` is high (default 6). `slow_tick` is ignored while it waits.
- R9: A `wake_req` while asleep with `sleep_mode` = 2'b00 (idle), 2'b01 (ADC noise reduction) or 2'b11 (standby) raises `run_en` right after that edge.
- R10: `wake_req` and `sleep_req` have no effect while `int_rst` is high. `wake_req` while running has no effect either.
- R11: Whenever `int_rst` is low, `presc_code` equals PRESC_DIV8 (default 4'd3, meaning divide by 2^3).
- R12: `run_en` is never high while `int_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_req | input | 1 | Combined reset request, active high, acts asynchronously |
| slow_tick | input | 1 | One-cycle enable per slow-oscillator period |
| osc_tick | input | 1 | One-cycle enable per main-oscillator period |
| sleep_req | input | 1 | Request to enter sleep while running |
| wake_req | input | 1 | Wake request while asleep |
| sleep_mode | input | 2 | 00 idle, 01 ADC noise reduction, 10 power-down, 11 standby |
| int_rst | output | 1 | Internal reset to the rest of the chip |
| cfg_load | output | 1 | Configuration word fetch strobe |
| cfg_idx | output | IDX_W | Index of the word being fetched |
| run_en | output | 1 | Core may run |
| presc_code | output | PRESC_W | Default clock-prescale code |

## Verification
A phase counter that is off by one makes `cfg_load` rise one slow or main tick early or late. The bench spaces the ticks several cycles apart, so such an error moves the edge by whole tick periods. The same fault shifts the fall of `int_rst` by the same amount, within one sequence. If the phase state lets the wrong timebase advance it, the sequence finishes early, because the bench drives the other tick as noise during each phase. A wake path taken for the wrong mode shows within one or two cycles of the wake request, as `run_en` rising too soon or too late.

// File: rtl/startup_pkg.sv
package startup_pkg;

  typedef enum logic [2:0] {
    PH_SUPPLY,
    PH_OSC,
    PH_CFG,
    PH_RUN,
    PH_SLEEP,
    PH_WAKE
  } phase_e;

  localparam logic [1:0] SLP_IDLE  = 2'b00;
  localparam logic [1:0] SLP_ADC   = 2'b01;
  localparam logic [1:0] SLP_PDOWN = 2'b10;
  localparam logic [1:0] SLP_STBY  = 2'b11;

  // Phases that keep the chip held in reset.
  function automatic logic holds_reset(input phase_e p);
    return (p == PH_SUPPLY) || (p == PH_OSC) || (p == PH_CFG);
  endfunction

  // Only power-down stops the main oscillator.
  function automatic logic wake_needs_osc(input logic [1:0] mode);
    return mode == SLP_PDOWN;
  endfunction

  // Counter width that holds the largest phase length.
  function automatic int cnt_width(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/startup_tick_cnt.sv
module startup_tick_cnt #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          done
);
  // Terminal event: the last increment of the current phase.
  assign done = inc && (count == limit - CW'(1));

  always_ff @(posedge clk or posedge arst) begin
    if (arst)      count <= '0;
    else if (done) count <= '0;
    else if (inc)  count <= count + CW'(1);
  end
endmodule

// File: rtl/startup_phase_fsm.sv
module startup_phase_fsm
  import startup_pkg::*;
(
  input  logic       clk,
  input  logic       arst,
  input  logic       done,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic [1:0] sleep_mode,
  output phase_e     phase
);
  phase_e phase_d;

  always_comb begin
    phase_d = phase;
    unique case (phase)
      PH_SUPPLY: if (done) phase_d = PH_OSC;
      PH_OSC:    if (done) phase_d = PH_CFG;
      PH_CFG:    if (done) phase_d = PH_RUN;
      PH_RUN:    if (sleep_req) phase_d = PH_SLEEP;
      PH_SLEEP:  if (wake_req)
                   phase_d = wake_needs_osc(sleep_mode) ? PH_WAKE : PH_RUN;
      PH_WAKE:   if (done) phase_d = PH_RUN;
      default:   phase_d = PH_SUPPLY;
    endcase
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) phase <= PH_SUPPLY;
    else      phase <= phase_d;
  end
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int              SUPPLY_TICKS = 8192,
  parameter int              OSC_CYCLES   = 6,
  parameter int              CFG_WORDS    = 21,
  parameter int              WAKE_CYCLES  = 6,
  parameter int              PRESC_W      = 4,
  parameter logic [PRESC_W-1:0] PRESC_DIV8 = 4'd3,
  localparam int             IDX_W        = $clog2(CFG_WORDS)
) (
  input  logic               clk,
  input  logic               rst_req,
  input  logic               slow_tick,
  input  logic               osc_tick,
  input  logic               sleep_req,
  input  logic               wake_req,
  input  logic [1:0]         sleep_mode,
  output logic               int_rst,
  output logic               cfg_load,
  output logic [IDX_W-1:0]   cfg_idx,
  output logic               run_en,
  output logic [PRESC_W-1:0] presc_code
);
  localparam int CW = cnt_width(SUPPLY_TICKS, OSC_CYCLES, CFG_WORDS, WAKE_CYCLES);

  phase_e        phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          inc;
  logic          phase_done;
  logic          in_sleep;

  // Timebase and length for each phase.
  always_comb begin
    inc = 1'b0;
    lim = CW'(WAKE_CYCLES);
    unique case (phase)
      PH_SUPPLY: begin inc = slow_tick; lim = CW'(SUPPLY_TICKS); end
      PH_OSC:    begin inc = osc_tick;  lim = CW'(OSC_CYCLES);   end
      PH_CFG:    begin inc = 1'b1;      lim = CW'(CFG_WORDS);    end
      PH_WAKE:   begin inc = osc_tick;  lim = CW'(WAKE_CYCLES);  end
      default:   begin inc = 1'b0;      lim = CW'(WAKE_CYCLES);  end
    endcase
  end

  startup_tick_cnt #(.CW(CW)) u_cnt (
    .clk   (clk),
    .arst  (rst_req),
    .inc   (inc),
    .limit (lim),
    .count (cnt),
    .done  (phase_done)
  );

  startup_phase_fsm u_fsm (
    .clk        (clk),
    .arst       (rst_req),
    .done       (phase_done),
    .sleep_req  (sleep_req),
    .wake_req   (wake_req),
    .sleep_mode (sleep_mode),
    .phase      (phase)
  );

  assign in_sleep   = (phase == PH_SLEEP) && !rst_req;
  assign int_rst    = rst_req || holds_reset(phase);
  assign run_en     = (phase == PH_RUN) && !rst_req;
  assign cfg_load   = (phase == PH_CFG) && !rst_req;
  assign cfg_idx    = cfg_load ? IDX_W'(cnt) : '0;
  assign presc_code = PRESC_DIV8;
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk #(
  parameter int              CFG_WORDS  = 21,
  parameter int              IDX_W      = 5,
  parameter int              PRESC_W    = 4,
  parameter logic [PRESC_W-1:0] PRESC_DIV8 = 4'd3
) (
  input logic               clk,
  input logic               rst_req,
  input logic               sleep_req,
  input logic               wake_req,
  input logic [1:0]         sleep_mode,
  input logic               int_rst,
  input logic               cfg_load,
  input logic [IDX_W-1:0]   cfg_idx,
  input logic               run_en,
  input logic [PRESC_W-1:0] presc_code,
  input logic               in_sleep
);
  assert_req_holds_reset_R1: assert property (@(posedge clk) rst_req |-> int_rst);

  assert_release_after_last_word_R2: assert property (@(posedge clk) disable iff (rst_req)
    $fell(int_rst) |-> ($past(cfg_load) && $past(cfg_idx) == IDX_W'(CFG_WORDS - 1)));

  assert_load_inside_reset_R5: assert property (@(posedge clk) cfg_load |-> int_rst);

  assert_idx_idle_R5: assert property (@(posedge clk) !cfg_load |-> cfg_idx == '0);

  assert_idx_step_R5: assert property (@(posedge clk) disable iff (rst_req)
    (cfg_load && $past(cfg_load)) |-> cfg_idx == $past(cfg_idx) + IDX_W'(1));

  assert_sleep_drops_run_R7: assert property (@(posedge clk) disable iff (rst_req)
    (run_en && sleep_req) |=> !run_en);

  assert_pdown_waits_R8: assert property (@(posedge clk) disable iff (rst_req)
    (in_sleep && wake_req && sleep_mode == 2'b10) |=> !run_en);

  assert_light_wake_fast_R9: assert property (@(posedge clk) disable iff (rst_req)
    (in_sleep && wake_req && sleep_mode != 2'b10) |=> run_en);

  assert_prescale_default_R11: assert property (@(posedge clk)
    !int_rst |-> presc_code == PRESC_DIV8);

  assert_no_run_in_reset_R12: assert property (@(posedge clk) int_rst |-> !run_en);
endmodule

bind startup_seq startup_seq_chk #(
  .CFG_WORDS (CFG_WORDS),
  .IDX_W     (IDX_W),
  .PRESC_W   (PRESC_W),
  .PRESC_DIV8(PRESC_DIV8)
) u_chk (
  .clk        (clk),
  .rst_req    (rst_req),
  .sleep_req  (sleep_req),
  .wake_req   (wake_req),
  .sleep_mode (sleep_mode),
  .int_rst    (int_rst),
  .cfg_load   (cfg_load),
  .cfg_idx    (cfg_idx),
  .run_en     (run_en),
  .presc_code (presc_code),
  .in_sleep   (in_sleep)
);

// File: tb/startup_seq_tb.sv
module startup_seq_tb;
  localparam int SUP   = 10;
  localparam int OSC   = 6;
  localparam int CFG   = 21;
  localparam int WAKE  = 6;
  localparam int IDX_W = $clog2(CFG);

  logic clk = 1'b0;
  logic rst_req = 1'b1;
  logic slow_tick = 1'b0, osc_tick = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
  logic [1:0] sleep_mode = 2'b00;
  logic int_rst, cfg_load, run_en;
  logic [IDX_W-1:0] cfg_idx;
  logic [3:0] presc_code;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  startup_seq #(
    .SUPPLY_TICKS(SUP), .OSC_CYCLES(OSC), .CFG_WORDS(CFG), .WAKE_CYCLES(WAKE)
  ) u_dut (
    .clk(clk), .rst_req(rst_req), .slow_tick(slow_tick), .osc_tick(osc_tick),
    .sleep_req(sleep_req), .wake_req(wake_req), .sleep_mode(sleep_mode),
    .int_rst(int_rst), .cfg_load(cfg_load), .cfg_idx(cfg_idx),
    .run_en(run_en), .presc_code(presc_code)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Drive inputs for one clock edge, return at the following falling edge.
  task automatic cyc(input logic s, input logic o);
    slow_tick = s;
    osc_tick  = o;
    @(negedge clk);
    slow_tick = 1'b0;
    osc_tick  = 1'b0;
  endtask

  // Release reset and walk the whole sequence, with the other timebase as noise.
  task automatic run_full(input bit noisy);
    bit ok;
    rst_req = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < SUP; i++) begin
      if (noisy && i == 2) begin wake_req = 1'b1; sleep_req = 1'b1; end
      cyc(1'b0, 1'b1);
      wake_req = 1'b0; sleep_req = 1'b0;
      if (!(int_rst && !cfg_load && !run_en)) ok = 1'b0;
      cyc(1'b1, 1'b0);
      if (i < SUP - 1 && cfg_load) ok = 1'b0;
    end
    chk("R3", "supply phase held reset, osc ticks ignored", ok, 1);
    chk("R10", "no run during supply despite wake/sleep", run_en, 0);
    ok = 1'b1;
    for (int j = 0; j < OSC; j++) begin
      if (cfg_load || !int_rst) ok = 1'b0;
      cyc(1'b1, 1'b0);
      if (cfg_load) ok = 1'b0;
      cyc(1'b0, 1'b1);
    end
    chk("R4", "osc phase length, slow ticks ignored", ok, 1);
    ok = 1'b1;
    for (int k = 0; k < CFG; k++) begin
      if (!(cfg_load && int_rst && cfg_idx == IDX_W'(k))) ok = 1'b0;
      cyc(1'b0, 1'b0);
    end
    chk("R5", "config window strobes and indices", ok, 1);
    chk("R2", "int_rst released after last word", int_rst, 0);
    chk("R5", "strobe idle after window", cfg_load, 0);
    chk("R5", "index idle after window", cfg_idx, 0);
    chk("R12", "run_en after release", run_en, 1);
    chk("R11", "prescale code after release", presc_code, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "int_rst at reset", int_rst, 1);
    chk("R12", "run_en at reset", run_en, 0);
    chk("R5", "cfg_load at reset", cfg_load, 0);

    run_full(1'b1);

    // R10: wake while running has no effect.
    sleep_mode = 2'b10;
    wake_req = 1'b1; cyc(1'b0, 1'b0); wake_req = 1'b0;
    chk("R10", "wake while running ignored", run_en, 1);

    // R6: abort inside the config window, then inside the supply delay.
    rst_req = 1'b1;
    #1;
    chk("R1", "int_rst same cycle as request", int_rst, 1);
    chk("R6", "strobe cleared by request", cfg_load, 0);
    @(negedge clk);
    rst_req = 1'b0;
    for (int i = 0; i < SUP; i++) cyc(1'b1, 1'b0);
    for (int j = 0; j < OSC; j++) cyc(1'b0, 1'b1);
    repeat (5) cyc(1'b0, 1'b0);
    chk("R6", "mid-window index before abort", cfg_idx, 5);
    rst_req = 1'b1;
    #1;
    chk("R1", "reset during config window", int_rst, 1);
    @(negedge clk);
    run_full(1'b0);
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    for (int i = 0; i < SUP - 3; i++) cyc(1'b1, 1'b0);
    rst_req = 1'b1;
    @(negedge clk);
    chk("R6", "held through mid-supply abort", int_rst, 1);
    run_full(1'b0);

    // Sleep and wake over all modes.
    for (int m = 0; m < 4; m++) begin
      sleep_mode = 2'(m);
      sleep_req = 1'b1; cyc(1'b0, 1'b0); sleep_req = 1'b0;
      chk("R7", $sformatf("asleep mode %0d", m), run_en, 0);
      repeat (3) cyc(1'b1, 1'b1);
      chk("R7", "stays asleep without wake", run_en, 0);
      wake_req = 1'b1; cyc(1'b0, 1'b0); wake_req = 1'b0;
      if (m == 2) begin
        bit ok;
        ok = 1'b1;
        chk("R8", "power-down not awake yet", run_en, 0);
        for (int t = 0; t < WAKE - 1; t++) begin
          cyc(1'b1, 1'b0);
          cyc(1'b0, 1'b1);
          if (run_en || int_rst) ok = 1'b0;
        end
        chk("R8", "power-down waits for osc ticks", ok, 1);
        cyc(1'b0, 1'b1);
        chk("R8", "power-down awake after last tick", run_en, 1);
      end else begin
        chk("R9", $sformatf("fast wake mode %0d", m), run_en, 1);
      end
      chk("R11", "no reset across sleep", int_rst, 0);
    end
    summary();
  end
endmodule